// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Walker

This block is a single-channel DMA sequencer that walks a linked list of 32-byte descriptors kept in host memory. Software loads a 64-bit list pointer, then writes the control/status register with the enable, scatter-gather mode and start bits set. The engine fetches each descriptor one word at a time over a simple request/acknowledge memory read port. For every descriptor with a nonzero byte count it raises a transfer request that carries the bus address, the length and the direction. It adds each acknowledged length to a bytes-transferred counter and then follows the descriptor's next pointer.

Three flags ride in the low bits of the next-pointer word and are masked away before the word is used as an address. They mark end of chain, ask for an interrupt, and pick the direction. A list whose tail points back at its head and has no end-of-chain flag runs as an endless ring. Software stops it with abort. The data path and the real bus protocol lie outside this block, and the transfer port stands in for them.

Top module: `sgdma_walker`

## Requirements
- R1: After reset, the control/status register at offset 0x20 reads 0x10 (done set, everything else clear), bytes-transferred at 0x24 reads 0, `irq` is low and neither `mem_req` nor `xfer_req` is raised.
- R2: A write to 0x20 with bit 0 (enable), bit 8 (scatter-gather mode) and bit 1 (start) all set, made while done is set, clears done and starts fetching. The fetch reads the eight words of the descriptor at consecutive 4-byte addresses from the list pointer. Word 0 is the low bus address, word 1 the high bus address, word 4 the byte count, word 6 the low next word and word 7 the high next word.
- R3: A start write that lacks enable or scatter-gather mode has no effect, and the engine stays idle with done set.
- R4: For a descriptor with a nonzero count, `xfer_req` rises with `xfer_addr` = {word 1, word 0}, `xfer_len` = word 4 and `xfer_to_host` = bit 3 of word 6. These outputs hold steady until `xfer_ack`.
- R5: Bytes-transferred at 0x24 is the sum of all acknowledged lengths since the last accepted start, which clears it.
- R6: A descriptor whose count is zero issues no transfer request.
- R7: The next descriptor address is {word 7, word 6 with bits 4:0 cleared}. The flag bits and bit 4 of word 6 never reach the address.
- R8: After a descriptor whose word 6 has bit 1 (end of chain) set, the engine stops with done set and issues no further requests.
- R9: After a descriptor whose word 6 has bit 2 set, the interrupt flag (bit 5 of 0x20) is set and `irq` is high. Writing 1 to bit 5 clears it, writing 0 leaves it set, and descriptors without bit 2 never set it.
- R10: A list without an end-of-chain flag that points back to its first descriptor keeps issuing transfers around the ring with done clear.
- R11: Writing bit 2 (abort) to 0x20 while done is clear drops any request on the next cycle and sets done. The same write while done is set changes nothing.
- R12: Offset 0x04 reads the capability value 0x101 (one channel in bits 3:0, 64-bit addressing in bit 8). The list pointer halves read back at 0x10 (low) and 0x14 (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register byte offset in the channel window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 64 | Descriptor word byte address |
| mem_ack | input | 1 | Read acknowledge, mem_rdata valid |
| mem_rdata | input | 32 | Descriptor word read data |
| xfer_req | output | 1 | Transfer request |
| xfer_addr | output | 64 | Transfer bus address |
| xfer_len | output | 32 | Transfer byte count |
| xfer_to_host | output | 1 | Direction: 1 toward the host bus |
| xfer_ack | input | 1 | Transfer acknowledge |
| irq | output | 1 | Level interrupt while the interrupt flag is set |

## Verification
The walker runs a three-entry chain with a 64-bit bus address, stray bits below the alignment in a next pointer, a zero-length entry and a final entry that carries both end-of-chain and interrupt. This separates correct masking, skipping and stopping from an engine that fetches from an unaligned pointer or requests empty transfers. A two-entry ring with no end flag runs for five transfers and is then aborted while its sixth request is held. This tells a real loop-back apart from a stop at the tail, and a cancelled request from one left hanging. Start writes missing a mode bit, interrupt-clear writes of 0 and 1, and an abort sent to an idle channel each show that the ignored write leaves no trace.

// File: rtl/sgdma_walker.sv
module sgdma_walker #(
  parameter int DESC_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xfer_req,
  output logic [63:0] xfer_addr,
  output logic [31:0] xfer_len,
  output logic        xfer_to_host,
  input  logic        xfer_ack,
  output logic        irq
);
  localparam int IW = $clog2(DESC_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DECIDE, S_XFER} state_t;

  state_t      st;
  logic [IW-1:0] widx;
  logic [63:0] ptr;
  logic [31:0] lp_lo, lp_hi;
  logic [31:0] d_alo, d_ahi, d_len, d_nlo, d_nhi;
  logic [31:0] bytes_q;
  logic        en_q, sg_q, done_q, irq_q;

  wire wr_csr   = reg_wr && reg_addr == 6'h20;
  wire go       = wr_csr && reg_wdata[0] && reg_wdata[1] && reg_wdata[8] && st == S_IDLE;
  wire stop     = wr_csr && reg_wdata[2] && st != S_IDLE;
  wire desc_end = (st == S_DECIDE && d_len == 32'd0) || (st == S_XFER && xfer_ack);

  assign mem_req      = st == S_FETCH;
  assign mem_addr     = {ptr[63:5], widx, 2'b00};
  assign xfer_req     = st == S_XFER;
  assign xfer_addr    = {d_ahi, d_alo};
  assign xfer_len     = d_len;
  assign xfer_to_host = d_nlo[3];
  assign irq          = irq_q;

  always_comb begin
    case (reg_addr)
      6'h04:   reg_rdata = 32'h0000_0101;
      6'h10:   reg_rdata = lp_lo;
      6'h14:   reg_rdata = lp_hi;
      6'h20:   reg_rdata = {23'd0, sg_q, 2'b00, irq_q, done_q, 3'b000, en_q};
      6'h24:   reg_rdata = bytes_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; ptr <= '0;
      lp_lo <= '0; lp_hi <= '0; bytes_q <= '0;
      d_alo <= '0; d_ahi <= '0; d_len <= '0; d_nlo <= '0; d_nhi <= '0;
      en_q <= 1'b0; sg_q <= 1'b0; done_q <= 1'b1; irq_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 6'h10) lp_lo <= reg_wdata;
      if (reg_wr && reg_addr == 6'h14) lp_hi <= reg_wdata;
      if (wr_csr) begin
        en_q <= reg_wdata[0];
        sg_q <= reg_wdata[8];
        if (reg_wdata[5]) irq_q <= 1'b0;
      end
      if (stop) begin
        st <= S_IDLE;
        done_q <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (go) begin
            st <= S_FETCH; widx <= '0; done_q <= 1'b0; bytes_q <= '0;
            ptr <= {lp_hi, lp_lo[31:5], 5'd0};
          end
          S_FETCH: if (mem_ack) begin
            case (widx)
              IW'(0): d_alo <= mem_rdata;
              IW'(1): d_ahi <= mem_rdata;
              IW'(4): d_len <= mem_rdata;
              IW'(6): d_nlo <= mem_rdata;
              IW'(7): d_nhi <= mem_rdata;
              default: ;
            endcase
            widx <= widx + 1'b1;
            if (widx == IW'(DESC_WORDS - 1)) st <= S_DECIDE;
          end
          S_DECIDE: if (d_len != 32'd0) st <= S_XFER;
          S_XFER: if (xfer_ack) bytes_q <= bytes_q + d_len;
          default: st <= S_IDLE;
        endcase
        if (desc_end) begin
          if (d_nlo[2]) irq_q <= 1'b1;
          widx <= '0;
          if (d_nlo[1]) begin
            st <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_FETCH;
            ptr <= {d_nhi, d_nlo[31:5], 5'd0};
          end
        end
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !mem_req && !xfer_req);
  p_fetch_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr[4:0] == 5'd0);
  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack && !stop |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_to_host));
  p_no_empty_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_len != 32'd0);
  p_abort_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> done_q && !mem_req && !xfer_req);
  p_single_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));
endmodule

// File: tb/sgdma_walker_bench.sv
module sgdma_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_ack = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        xfer_req, xfer_to_host, xfer_ack = 1'b0, irq;
  logic [63:0] xfer_addr;
  logic [31:0] xfer_len;

  always #4 clk = ~clk;

  sgdma_walker u_sgdma_walker (.*);

  typedef struct packed { logic [63:0] a; logic [31:0] n; logic h; } item_t;
  item_t exp_q[$];
  logic [31:0] mem [256];
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_rdata = mem[mem_addr[9:2]];
      mem_ack = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (xfer_ack) xfer_ack = 1'b0;
    else if (xfer_req && exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      chk(xfer_addr == e.a, "R4 addr", xfer_addr, e.a);
      chk(xfer_len == e.n, "R4 len", {32'd0, xfer_len}, {32'd0, e.n});
      chk(xfer_to_host == e.h, "R4 dir", {63'd0, xfer_to_host}, {63'd0, e.h});
      xfer_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", 0, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic push(input logic [63:0] a, input logic [31:0] n, input logic h);
    item_t e;
    e.a = a; e.n = n; e.h = h;
    exp_q.push_back(e);
  endtask

  task automatic put_desc(input int base, input logic [31:0] alo, input logic [31:0] ahi,
                          input logic [31:0] len, input logic [31:0] nlo, input logic [31:0] nhi);
    mem[(base >> 2) + 0] = alo;
    mem[(base >> 2) + 1] = ahi;
    mem[(base >> 2) + 4] = len;
    mem[(base >> 2) + 6] = nlo;
    mem[(base >> 2) + 7] = nhi;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(6'h20, v);
      if (v[4]) break;
    end
  endtask

  logic [31:0] v;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(6'h20, v); chk(v == 32'h10, "R1 csr", v, 32'h10);
    rd(6'h24, v); chk(v == 0, "R1 bytes", v, 0);
    chk(!irq && !mem_req && !xfer_req, "R1 outputs", {irq, mem_req, xfer_req}, 0);
    rd(6'h04, v); chk(v == 32'h101, "R12 capability", v, 32'h101);

    // chain: masked next pointer, zero-length entry, final end+irq
    put_desc(32'h100, 32'h8000_0000, 32'h1, 16, 32'h138, 0);
    put_desc(32'h120, 32'h1111_0000, 32'h0, 0, 32'h140, 0);
    put_desc(32'h140, 32'h2000, 32'h0, 8, 32'h146, 0);
    push(64'h1_8000_0000, 16, 1'b1);
    push(64'h2000, 8, 1'b0);
    wr(6'h10, 32'h100);
    wr(6'h14, 32'h0);
    rd(6'h10, v); chk(v == 32'h100, "R12 pointer lo", v, 32'h100);
    wr(6'h20, 32'h103);
    @(negedge clk);
    rd(6'h20, v); chk(v[4] == 1'b0, "R2 done clears on start", v, 0);
    wait_done();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 R7 all transfers seen", exp_q.size(), 0);
    chk(!xfer_req && !mem_req, "R8 stopped", {mem_req, xfer_req}, 0);
    rd(6'h24, v); chk(v == 24, "R5 bytes", v, 24);
    rd(6'h20, v); chk(v[5] == 1'b1 && irq, "R9 irq set", {v[5], irq}, 2'b11);

    wr(6'h20, 32'h0);
    @(negedge clk);
    chk(irq == 1'b1, "R9 write 0 keeps flag", irq, 1);
    wr(6'h20, 32'h20);
    @(negedge clk);
    chk(irq == 1'b0, "R9 write 1 clears", irq, 0);

    wr(6'h20, 32'h002);
    wr(6'h20, 32'h102);
    wr(6'h20, 32'h003);
    repeat (5) @(negedge clk);
    rd(6'h20, v); chk(v[4] && !mem_req, "R3 start ignored", {v[4], mem_req}, 2'b10);

    // ring of two entries, no end flag
    put_desc(32'h200, 32'h3000, 32'h0, 4, 32'h220, 0);
    put_desc(32'h220, 32'h4000, 32'h0, 12, 32'h208, 0);
    for (int k = 0; k < 5; k++)
      if (k % 2 == 0) push(64'h3000, 4, 1'b0); else push(64'h4000, 12, 1'b1);
    wr(6'h10, 32'h200);
    wr(6'h20, 32'h103);
    for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    rd(6'h20, v); chk(v[4] == 1'b0 && xfer_req, "R10 ring still running", {v[4], xfer_req}, 2'b01);
    chk(irq == 1'b0, "R9 no flag no irq", irq, 0);
    rd(6'h24, v); chk(v == 36, "R5 cleared on start and summed", v, 36);
    @(negedge clk);
    reg_addr = 6'h20; reg_wdata = 32'h4; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(!xfer_req && !mem_req, "R11 abort drops request", {mem_req, xfer_req}, 0);
    rd(6'h20, v); chk(v[4] == 1'b1, "R11 abort sets done", v, 32'h10);

    wr(6'h20, 32'h4);
    repeat (3) @(negedge clk);
    rd(6'h24, v); chk(v == 36, "R11 abort when idle no effect", v, 36);
    chk(!xfer_req && !mem_req, "R11 idle stays quiet", {mem_req, xfer_req}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule